// File: doc/BRIEF.md
# Chip-Level Memory Self-Test Hub

This block sits between the chip-level test controls and a set of memory self-test engines (four by default). It copies the global start, reset and debug-map commands to every engine and gives each engine its own hold line, which pauses that memory for retention testing. It reduces the engines' per-unit completion and error flags to one chip-level pair, and routes exactly one engine's debug stream to a shared diagnostic output.

A single enable input marks whether self-test is active. While it is low, every line toward the engines and every chip-level result is forced to 0, so that nothing leaks out in functional mode. An optional banked mode splits the engines into a lower and an upper half and starts the upper half only after the whole lower half has finished, which caps the number of memories being exercised at once.

Top module: `mbist_hub`

## Requirements
- R1: With `test_en` high, every bit of `unit_reset` equals `g_reset` in the same cycle.
- R2: With `test_en` high, every bit of `unit_bitmap` equals `g_bitmap` and `unit_hold` equals `hold_in`, in the same cycle.
- R3: `chip_done` is registered: it is 1 one clock after a cycle in which `test_en` is high and every bit of `unit_done` is 1, and 0 otherwise.
- R4: `chip_fail` is registered: it is 1 one clock after a cycle in which `test_en` is high and at least one bit of `unit_fail` is 1, and 0 otherwise.
- R5: With `test_en` high, `diag_out` carries the slice `unit_diag[i*DIAG_W +: DIAG_W]` of the lowest-numbered unit i whose `hold_in[i]` is 0.
- R6: With `test_en` high and every `hold_in` bit set, `diag_out` is 0.
- R7: With `test_en` low, `unit_invoke`, `unit_reset`, `unit_bitmap`, `unit_hold` and `diag_out` are 0 at once, and `chip_done` and `chip_fail` are 0 from the next clock.
- R8: With `test_en` high and `bank_mode` low, every bit of `unit_invoke` equals `g_invoke`.
- R9: With `test_en` high and `bank_mode` high, the lower half of units (indices below N_UNITS/2) receive `g_invoke` directly; each upper unit receives `g_invoke` only if, in the previous cycle, `test_en` was high and every lower unit's `unit_done` bit was 1.
- R10: While `rst_n` is low, `chip_done` and `chip_fail` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the hub's registers |
| test_en | input | 1 | Self-test enabled; low forces safe defaults |
| bank_mode | input | 1 | 1 = start upper half only after lower half is done |
| g_invoke | input | 1 | Global start command |
| g_reset | input | 1 | Global engine reset command |
| g_bitmap | input | 1 | Global debug-map command |
| hold_in | input | N_UNITS | Per-unit hold / diagnostic select |
| unit_invoke | output | N_UNITS | Start line per engine |
| unit_reset | output | N_UNITS | Reset line per engine |
| unit_bitmap | output | N_UNITS | Debug-map line per engine |
| unit_hold | output | N_UNITS | Hold line per engine |
| unit_done | input | N_UNITS | Completion flag per engine |
| unit_fail | input | N_UNITS | Error flag per engine |
| unit_diag | input | N_UNITS*DIAG_W | Packed debug streams, unit i at bits i*DIAG_W |
| chip_done | output | 1 | Registered AND of completion flags |
| chip_fail | output | 1 | Registered OR of error flags |
| diag_out | output | DIAG_W | Selected debug stream |

## Verification
The fan-out lines and the diagnostic output are combinational, so the bench checks them a nanosecond after driving new inputs on the falling edge, within the same cycle. `chip_done`, `chip_fail` and the lower-bank completion state that gates the upper start lines each pass through one register, so the bench computes their expected values at the rising edge from the inputs then applied and compares them after the next falling-edge drive. The hub's behaviour is exercised under seeded random inputs with both bank settings, plus directed cases for all-held, all-done, disabled and reset.

// File: rtl/mbist_hub.sv
module mbist_hub #(
  parameter int N_UNITS = 4,
  parameter int DIAG_W  = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        test_en,
  input  logic                        bank_mode,
  input  logic                        g_invoke,
  input  logic                        g_reset,
  input  logic                        g_bitmap,
  input  logic [N_UNITS-1:0]          hold_in,
  output logic [N_UNITS-1:0]          unit_invoke,
  output logic [N_UNITS-1:0]          unit_reset,
  output logic [N_UNITS-1:0]          unit_bitmap,
  output logic [N_UNITS-1:0]          unit_hold,
  input  logic [N_UNITS-1:0]          unit_done,
  input  logic [N_UNITS-1:0]          unit_fail,
  input  logic [N_UNITS*DIAG_W-1:0]   unit_diag,
  output logic                        chip_done,
  output logic                        chip_fail,
  output logic [DIAG_W-1:0]           diag_out
);
  localparam int LOW_N = N_UNITS / 2;

  logic low_bank_ok;
  logic [DIAG_W-1:0] diag_sel;
  logic              diag_found;

  assign unit_reset  = {N_UNITS{test_en & g_reset}};
  assign unit_bitmap = {N_UNITS{test_en & g_bitmap}};
  assign unit_hold   = hold_in & {N_UNITS{test_en}};

  genvar gi;
  generate
    for (gi = 0; gi < N_UNITS; gi++) begin : g_inv
      if (gi < LOW_N) begin : g_low
        assign unit_invoke[gi] = test_en & g_invoke;
      end else begin : g_high
        assign unit_invoke[gi] = test_en & g_invoke & (~bank_mode | low_bank_ok);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chip_done   <= 1'b0;
      chip_fail   <= 1'b0;
      low_bank_ok <= 1'b0;
    end else begin
      chip_done   <= test_en & (&unit_done);
      chip_fail   <= test_en & (|unit_fail);
      low_bank_ok <= test_en & (&unit_done[LOW_N-1:0]);
    end
  end

  always_comb begin
    diag_sel   = '0;
    diag_found = 1'b0;
    for (int i = 0; i < N_UNITS; i++) begin
      if (!diag_found && !hold_in[i]) begin
        diag_sel   = unit_diag[i*DIAG_W +: DIAG_W];
        diag_found = 1'b1;
      end
    end
  end

  assign diag_out = test_en ? diag_sel : '0;

  assert_done_and_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && (&unit_done)) |=> chip_done);

  assert_fail_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && (|unit_fail)) |=> chip_fail);

  assert_all_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && (&hold_in)) |-> (diag_out == '0));

  assert_safe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !test_en |-> (unit_invoke == '0 && unit_hold == '0 && unit_reset == '0 && diag_out == '0));

  assert_bank_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_mode && unit_invoke[N_UNITS-1]) |-> $past(test_en && (&unit_done[LOW_N-1:0])));
endmodule

// File: tb/test_mbist_hub.sv
module test_mbist_hub;
  localparam int N = 4;
  localparam int W = 8;
  localparam int LOW = N / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic test_en = 1'b0, bank_mode = 1'b0, g_invoke = 1'b0, g_reset = 1'b0, g_bitmap = 1'b0;
  logic [N-1:0] hold_in = '0, unit_done = '0, unit_fail = '0;
  logic [N*W-1:0] unit_diag = '0;
  logic [N-1:0] unit_invoke, unit_reset, unit_bitmap, unit_hold;
  logic chip_done, chip_fail;
  logic [W-1:0] diag_out;

  int checks = 0, fails = 0;
  logic exp_done = 1'b0, exp_fail = 1'b0, exp_low = 1'b0;

  always #4 clk = ~clk;

  mbist_hub #(.N_UNITS(N), .DIAG_W(W)) i_mbist_hub (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .bank_mode(bank_mode),
    .g_invoke(g_invoke), .g_reset(g_reset), .g_bitmap(g_bitmap), .hold_in(hold_in),
    .unit_invoke(unit_invoke), .unit_reset(unit_reset), .unit_bitmap(unit_bitmap),
    .unit_hold(unit_hold), .unit_done(unit_done), .unit_fail(unit_fail),
    .unit_diag(unit_diag), .chip_done(chip_done), .chip_fail(chip_fail), .diag_out(diag_out)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_done <= 1'b0; exp_fail <= 1'b0; exp_low <= 1'b0;
    end else begin
      exp_done <= test_en & (&unit_done);
      exp_fail <= test_en & (|unit_fail);
      exp_low  <= test_en & (&unit_done[LOW-1:0]);
    end
  end

  function automatic logic [W-1:0] model_diag(logic en, logic [N-1:0] h, logic [N*W-1:0] d);
    if (!en) return '0;
    for (int i = 0; i < N; i++) if (!h[i]) return d[i*W +: W];
    return '0;
  endfunction

  function automatic logic [N-1:0] model_invoke(logic en, logic bm, logic inv, logic low_ok);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = en & inv & ((i < LOW) | ~bm | low_ok);
    return r;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(unit_reset == {N{test_en & g_reset}}, "R1 reset fan-out", unit_reset, {N{test_en & g_reset}});
    chk(unit_bitmap == {N{test_en & g_bitmap}}, "R2 bitmap fan-out", unit_bitmap, {N{test_en & g_bitmap}});
    chk(unit_hold == (hold_in & {N{test_en}}), "R2 hold fan-out", unit_hold, hold_in & {N{test_en}});
    chk(chip_done == exp_done, "R3 chip_done", chip_done, exp_done);
    chk(chip_fail == exp_fail, "R4 chip_fail", chip_fail, exp_fail);
    chk(diag_out == model_diag(test_en, hold_in, unit_diag), (&hold_in) ? "R6 all held" : "R5 diag select",
        diag_out, model_diag(test_en, hold_in, unit_diag));
    chk(unit_invoke == model_invoke(test_en, bank_mode, g_invoke, exp_low),
        bank_mode ? "R9 banked invoke" : "R8 invoke fan-out",
        unit_invoke, model_invoke(test_en, bank_mode, g_invoke, exp_low));
    if (!test_en)
      chk(unit_invoke == '0 && unit_reset == '0 && diag_out == '0 && unit_hold == '0, "R7 safe defaults",
          {unit_invoke, unit_reset, unit_hold}, '0);
  endtask

  task automatic drive(input logic en, input logic bm, input logic inv, input logic rs, input logic bmp,
                       input logic [N-1:0] h, input logic [N-1:0] dn, input logic [N-1:0] fl);
    @(negedge clk);
    test_en = en; bank_mode = bm; g_invoke = inv; g_reset = rs; g_bitmap = bmp;
    hold_in = h; unit_done = dn; unit_fail = fl;
    for (int i = 0; i < N; i++) unit_diag[i*W +: W] = W'($urandom);
    #1 check_all();
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    test_en = 1'b1; g_invoke = 1'b1; unit_done = '1; unit_fail = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(chip_done == 1'b0 && chip_fail == 1'b0, "R10 reset state", {chip_done, chip_fail}, 0);
    rst_n = 1'b1;

    drive(1, 0, 1, 0, 0, 4'b0000, 4'b1111, 4'b0000);
    drive(1, 0, 1, 0, 0, 4'b0000, 4'b1110, 4'b0000);
    drive(1, 0, 0, 0, 1, 4'b1111, 4'b0000, 4'b0100);
    drive(1, 0, 0, 1, 1, 4'b0101, 4'b0000, 4'b0000);
    drive(0, 1, 1, 1, 1, 4'b0011, 4'b1111, 4'b1111);
    drive(1, 1, 1, 0, 0, 4'b1110, 4'b0011, 4'b0000);
    drive(1, 1, 1, 0, 0, 4'b1100, 4'b0011, 4'b0000);
    drive(1, 1, 1, 0, 0, 4'b1000, 4'b0001, 4'b0000);
    drive(1, 1, 1, 0, 0, 4'b0000, 4'b1111, 4'b1000);

    for (int k = 0; k < 3000; k++) begin
      logic [N-1:0] dn;
      dn = ($urandom % 3 != 0) ? '1 : N'($urandom);
      drive(($urandom % 8) != 0, k >= 1500, ($urandom % 4) != 0, ($urandom % 5) == 0,
            $urandom % 2, N'($urandom), dn, (($urandom % 6) == 0) ? N'($urandom) : '0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule